// File: doc/BRIEF.md
# Small-Page NAND Read Responder

This block answers the read side of a small-page NAND device. It serves two chips behind one shared parallel control word, driven by a host that toggles the pins in software. The low byte of the word carries a command, an address or nothing. The upper bits carry two active-low chip enables, active-low read and write strobes, and two latch enables that mark a byte as a command or as an address. The block never models a busy period. Program, erase and status commands are not supported.

Each chip has its own read mode, address-cycle counter and linear byte pointer. A page is 528 bytes, made of 512 data bytes and 16 spare bytes, and a block is 32 pages. A read-mode command is followed by three address bytes. The first address byte is the column, offset by the read mode. The second address byte is the high part of the page number and the third is the low part. Each read strobe returns the byte at the pointer and then advances the pointer.

The byte image is computed from the pointer rather than stored. By default every byte reads 0xFF, as in an erased device. A parameter switches to an address-derived pattern so that the pointer arithmetic can be observed from outside. The pointer is `PTR_W` bits wide and wraps modulo 2^`PTR_W`.

Top module: `nandrd_responder`

## Requirements
- R1: After a synchronous active-low reset, `rd_drive` is 0, `rdy` is 2'b00, `err` is 2'b00 and `rd_data` is 0xFF. Both chips are in the wait state with pointer 0 and address-cycle count 0.
- R2: `bus_in[8]` is the enable of chip 0 and `bus_in[9]` is the enable of chip 1, both active low. When both are low, chip 0 is selected. When neither is low, the word has no effect on any output or on any chip state.
- R3: A falling edge of the write strobe `bus_in[11]` with the command latch `bus_in[13]` high takes `bus_in[7:0]` as a command. 0xFF returns the chip to the wait state. 0x00, 0x01 and 0x50 select read mode 1, 2 and 3 and clear the address-cycle count. The command latch wins over the address latch `bus_in[12]`.
- R4: The first address byte in a read mode loads the pointer with the byte value. Mode 2 adds 0x100 to it and mode 3 adds 0x200.
- R5: The second address byte adds byte×135168 (528×256) to the pointer. The third address byte adds byte×528.
- R6: A falling edge of the read strobe `bus_in[10]` on a selected chip sets `rd_data` to the image byte at that chip's pointer, sets `rd_drive` to 1 and then increments the pointer. The image byte is 0xFF when `PATTERN_FILL` is 0. When it is 1, the image byte is b0^b1^b2^b3 of the 32-bit zero-extended pointer, XORed with 0x5A for chip 1.
- R7: A cycle with both strobes high and a chip selected clears `rd_drive` on the next edge and sets that chip's ready bit `rdy[n]`. A ready bit, once set, stays set until reset.
- R8: A strobe held low for any number of cycles performs exactly one action, on its falling edge.
- R9: The following raise that chip's `err` bit and change neither its mode nor its pointer: an unknown command, a fourth address byte, or an address byte in the wait state. The `err` bit is sticky until reset.
- R10: The two chips keep separate modes, pointers and cycle counts. An action on one chip leaves the other unchanged.
- R11: Every pointer update wraps modulo 2^`PTR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the control word is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 14 | Control word: [7:0] byte, [8] chip 0 enable_n, [9] chip 1 enable_n, [10] read_n, [11] write_n, [12] address latch, [13] command latch |
| rd_data | output | 8 | Byte returned by the last read strobe |
| rd_drive | output | 1 | 1 while the responder owns the data lines |
| rdy | output | 2 | Per-chip ready bits, placed at positions 14 and 15 of the host's word |
| err | output | 2 | Per-chip sticky protocol-error flags |

## Verification
The bench builds the block with `PTR_W` = 16 and `PATTERN_FILL` = 1. The pattern fill makes every pointer value visible in the returned data. The 16-bit pointer brings the wrap at 0xFFFF within reach of a single address sequence. It also makes the 135168-byte row stride fold to a 4096 step. The bench sweeps all three read modes against several column, high-page and low-page bytes. It then drives each chip-select combination, each error kind after a fresh reset, and a long-held read strobe. Every returned byte is compared with a pointer model the bench computes from the address rules.

// File: rtl/nandrd_pkg.sv
// Package: shared constants, types and the image function of the NAND read
// responder. Assumes a control word of 14 bits with the layout set below.
package nandrd_pkg;

    localparam int NCHIP    = 2;
    localparam int WORD_W   = 14;
    localparam int BIT_CE0  = 8;
    localparam int BIT_CE1  = 9;
    localparam int BIT_RDN  = 10;
    localparam int BIT_WRN  = 11;
    localparam int BIT_ALAT = 12;
    localparam int BIT_CLAT = 13;

    localparam int          PAGE_BYTES  = 528;
    localparam logic [31:0] PAGE_STRIDE = 32'(PAGE_BYTES);
    localparam logic [31:0] ROW_STRIDE  = 32'(PAGE_BYTES * 256);

    localparam logic [7:0] CMD_WAIT  = 8'hFF;
    localparam logic [7:0] CMD_MODE1 = 8'h00;
    localparam logic [7:0] CMD_MODE2 = 8'h01;
    localparam logic [7:0] CMD_MODE3 = 8'h50;

    typedef enum logic [1:0] {
        MODE_WAIT = 2'd0,
        MODE_RD1  = 2'd1,
        MODE_RD2  = 2'd2,
        MODE_RD3  = 2'd3
    } rmode_e;

    // One decoded strobe action; cmd, addr and rd are mutually exclusive.
    typedef struct packed {
        logic       cmd;
        logic       addr;
        logic       rd;
        logic       idle;
        logic [7:0] data;
    } strobe_ev_t;

    // Column offset that a read mode preloads on the first address byte.
    function automatic logic [31:0] mode_offset(input rmode_e m);
        case (m)
            MODE_RD2: return 32'h100;
            MODE_RD3: return 32'h200;
            default:  return 32'h0;
        endcase
    endfunction

    // Byte image: erased (0xFF) or an address-derived pattern per chip.
    function automatic logic [7:0] image_byte(input logic [31:0] p,
                                              input logic        chip,
                                              input logic        patterned);
        if (!patterned) return 8'hFF;
        return p[7:0] ^ p[15:8] ^ p[23:16] ^ p[31:24] ^ (chip ? 8'h5A : 8'h00);
    endfunction

endpackage

// File: rtl/nandrd_strobe_decode.sv
// Strobe decoder: registers the two strobes once per clock and turns the
// sampled word into one-shot actions plus a chip selection.
// Assumes the word is already synchronous to clk and that every strobe
// level lasts at least one clock. The strobe history carries no reset, so
// it always equals the word of the previous edge.
module nandrd_strobe_decode
    import nandrd_pkg::*;
(
    input  logic              clk,
    input  logic [WORD_W-1:0] ctl_word,
    output strobe_ev_t        ev,
    output logic              sel_valid,
    output logic              sel_chip
);

    logic rdn_q;
    logic wrn_q;
    logic rd_fall;
    logic wr_fall;

    // Strobe history for falling-edge detection.
    always_ff @(posedge clk) begin
        rdn_q <= ctl_word[BIT_RDN];
        wrn_q <= ctl_word[BIT_WRN];
    end

    // Falling edges of the two strobes.
    always_comb begin
        rd_fall = rdn_q && !ctl_word[BIT_RDN];
        wr_fall = wrn_q && !ctl_word[BIT_WRN];
    end

    // Action decode: command latch beats address latch, writes beat reads.
    always_comb begin
        ev.data = ctl_word[7:0];
        ev.cmd  = wr_fall && ctl_word[BIT_CLAT];
        ev.addr = wr_fall && !ctl_word[BIT_CLAT] && ctl_word[BIT_ALAT];
        ev.rd   = rd_fall && !ev.cmd && !ev.addr;
        ev.idle = ctl_word[BIT_RDN] && ctl_word[BIT_WRN];
    end

    // Chip selection: chip 0 has priority when both enables are low.
    always_comb begin
        sel_valid = !ctl_word[BIT_CE0] || !ctl_word[BIT_CE1];
        sel_chip  = ctl_word[BIT_CE0];
    end

endmodule

// File: rtl/nandrd_chip.sv
// Per-chip state: read mode, address-cycle count, byte pointer, ready and
// sticky error. Acts only when 'act' marks this chip as selected.
// Assumes PTR_W between 10 and 32. The pointer wraps modulo 2^PTR_W.
module nandrd_chip
    import nandrd_pkg::*;
#(
    parameter int PTR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  strobe_ev_t       ev,
    output logic [PTR_W-1:0] ptr,
    output logic             err,
    output logic             rdy
);

    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    rmode_e      mode_q;
    logic [1:0]  cyc_q;
    logic [31:0] col_load;
    logic [31:0] row_add;
    logic [31:0] page_add;
    logic        addr_bad;

    // Address-cycle contributions and the address legality check.
    always_comb begin
        col_load = {24'd0, ev.data} + mode_offset(mode_q);
        row_add  = {24'd0, ev.data} * ROW_STRIDE;
        page_add = {24'd0, ev.data} * PAGE_STRIDE;
        addr_bad = (mode_q == MODE_WAIT) || (cyc_q == 2'd3);
    end

    // Command, address and read handling for this chip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_WAIT;
            cyc_q  <= 2'd0;
            ptr    <= '0;
            err    <= 1'b0;
            rdy    <= 1'b0;
        end else if (act) begin
            if (ev.idle) rdy <= 1'b1;
            if (ev.cmd) begin
                case (ev.data)
                    CMD_WAIT:  mode_q <= MODE_WAIT;
                    CMD_MODE1: begin mode_q <= MODE_RD1; cyc_q <= 2'd0; end
                    CMD_MODE2: begin mode_q <= MODE_RD2; cyc_q <= 2'd0; end
                    CMD_MODE3: begin mode_q <= MODE_RD3; cyc_q <= 2'd0; end
                    default:   err <= 1'b1;
                endcase
            end else if (ev.addr) begin
                if (addr_bad) begin
                    err <= 1'b1;
                end else begin
                    case (cyc_q)
                        2'd0:    ptr <= col_load[PTR_W-1:0];
                        2'd1:    ptr <= ptr + row_add[PTR_W-1:0];
                        default: ptr <= ptr + page_add[PTR_W-1:0];
                    endcase
                    cyc_q <= cyc_q + 2'd1;
                end
            end else if (ev.rd) begin
                ptr <= ptr + PTR_ONE;
            end
        end
    end

endmodule

// File: rtl/nandrd_responder.sv
// Top: two-chip NAND read responder. Decodes the shared control word,
// routes actions to the selected chip and returns its image byte on reads.
// Assumes a synchronous control word; PATTERN_FILL picks the byte image.
module nandrd_responder
    import nandrd_pkg::*;
#(
    parameter int PTR_W        = 24,
    parameter bit PATTERN_FILL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] bus_in,
    output logic [7:0]        rd_data,
    output logic              rd_drive,
    output logic [NCHIP-1:0]  rdy,
    output logic [NCHIP-1:0]  err
);

    strobe_ev_t       ev;
    logic             sel_valid;
    logic             sel_chip;
    logic [NCHIP-1:0] chip_act;
    logic [PTR_W-1:0] chip_ptr [NCHIP];

    nandrd_strobe_decode u_decode (
        .clk       (clk),
        .ctl_word  (bus_in),
        .ev        (ev),
        .sel_valid (sel_valid),
        .sel_chip  (sel_chip)
    );

    for (genvar g = 0; g < NCHIP; g++) begin : g_chip
        // Selection strobe for chip g.
        always_comb chip_act[g] = sel_valid && (int'(sel_chip) == g);

        nandrd_chip #(.PTR_W(PTR_W)) u_chip (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (chip_act[g]),
            .ev    (ev),
            .ptr   (chip_ptr[g]),
            .err   (err[g]),
            .rdy   (rdy[g])
        );
    end

    // Data return and ownership of the data lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 8'hFF;
            rd_drive <= 1'b0;
        end else if (sel_valid) begin
            if (ev.rd) begin
                rd_data  <= image_byte(32'(chip_ptr[sel_chip]), sel_chip, PATTERN_FILL);
                rd_drive <= 1'b1;
            end else if (ev.idle) begin
                rd_drive <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nandrd_checker.sv
// Checker: protocol properties of the NAND read responder, seen at its ports.
module nandrd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] bus_in,
    input logic [7:0]  rd_data,
    input logic        rd_drive,
    input logic [1:0]  rdy,
    input logic [1:0]  err
);

    AST_IGNORE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_in[8] && bus_in[9]) |=> ($stable(rd_data) && $stable(rd_drive) && $stable(err) && $stable(rdy))); // R2

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((!bus_in[8] || !bus_in[9]) && !bus_in[10] && $past(bus_in[10]) && bus_in[11]) |=> rd_drive); // R6

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!bus_in[8] || !bus_in[9]) && bus_in[10] && bus_in[11]) |=> (!rd_drive && (rdy != 2'b00))); // R7

    AST_RDY_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
        rdy[0] |=> rdy[0]); // R7

    AST_RDY_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
        rdy[1] |=> rdy[1]); // R7

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_in[10] && !$past(bus_in[10]) && bus_in[11]) |=> ($stable(rd_data) && $stable(rd_drive))); // R8

    AST_ERR_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
        err[0] |=> err[0]); // R9

    AST_ERR_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
        err[1] |=> err[1]); // R9

endmodule

bind nandrd_responder nandrd_checker u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_in   (bus_in),
    .rd_data  (rd_data),
    .rd_drive (rd_drive),
    .rdy      (rdy),
    .err      (err)
);

// File: tb/nandrd_responder_bench.sv
module nandrd_responder_bench;

    localparam int PW   = 16;
    localparam int MASK = (1 << PW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus;
    logic [7:0]  rd_data;
    logic        rd_drive;
    logic [1:0]  rdy;
    logic [1:0]  err;

    int nchecks = 0;
    int nfail   = 0;

    int m_ptr  [2];
    int m_mode [2];
    int m_cnt  [2];
    bit m_err  [2];
    bit m_rdy  [2];
    int m_data;
    bit m_drv;

    always #10 clk = ~clk;

    nandrd_responder #(.PTR_W(PW), .PATTERN_FILL(1'b1)) u_nandrd_responder (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (bus),
        .rd_data  (rd_data),
        .rd_drive (rd_drive),
        .rdy      (rdy),
        .err      (err)
    );

    // sel: 0 chip0 only, 1 chip1 only, 2 both enables low, 3 none
    function automatic logic [13:0] mk(int sel, bit re_n, bit we_n, bit ale, bit cle, logic [7:0] b);
        logic [13:0] v;
        v[7:0] = b;
        v[8]   = !(sel == 0 || sel == 2);
        v[9]   = !(sel == 1 || sel == 2);
        v[10]  = re_n;
        v[11]  = we_n;
        v[12]  = ale;
        v[13]  = cle;
        return v;
    endfunction

    function automatic int eff(int sel);
        if (sel == 1) return 1;
        if (sel == 3) return -1;
        return 0;
    endfunction

    function automatic int pat(int p, int c);
        logic [31:0] q;
        logic [7:0]  r;
        q = 32'(p);
        r = q[7:0] ^ q[15:8] ^ q[23:16] ^ q[31:24] ^ ((c == 1) ? 8'h5A : 8'h00);
        return int'(r);
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    endtask

    task automatic chk(string tag, int act, int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_status(string tag);
        chk({tag, " err"}, int'(err), (int'(m_err[1]) << 1) | int'(m_err[0]));
        chk({tag, " rdy R7"}, int'(rdy), (int'(m_rdy[1]) << 1) | int'(m_rdy[0]));
        chk({tag, " drive"}, int'(rd_drive), int'(m_drv));
        chk({tag, " data"}, int'(rd_data), m_data);
    endtask

    task automatic do_reset(string tag);
        rst_n = 1'b0;
        bus   = mk(3, 1, 1, 0, 0, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin
            m_ptr[c] = 0; m_mode[c] = 0; m_cnt[c] = 0; m_err[c] = 0; m_rdy[c] = 0;
        end
        m_data = 8'hFF;
        m_drv  = 0;
        @(negedge clk);
        chk_status(tag);
    endtask

    // Model of one latched byte, from R3, R4, R5, R9, R11.
    task automatic m_write(int c, bit ale, bit cle, logic [7:0] b);
        if (cle) begin
            case (b)
                8'hFF:   m_mode[c] = 0;
                8'h00:   begin m_mode[c] = 1; m_cnt[c] = 0; end
                8'h01:   begin m_mode[c] = 2; m_cnt[c] = 0; end
                8'h50:   begin m_mode[c] = 3; m_cnt[c] = 0; end
                default: m_err[c] = 1;
            endcase
        end else if (ale) begin
            if (m_mode[c] == 0 || m_cnt[c] == 3) begin
                m_err[c] = 1;
            end else begin
                case (m_cnt[c])
                    0: m_ptr[c] = (int'(b) + (m_mode[c] == 2 ? 256 : (m_mode[c] == 3 ? 512 : 0))) & MASK;
                    1: m_ptr[c] = (m_ptr[c] + int'(b) * 135168) & MASK;
                    default: m_ptr[c] = (m_ptr[c] + int'(b) * 528) & MASK;
                endcase
                m_cnt[c]++;
            end
        end
    endtask

    task automatic op_write(int sel, bit ale, bit cle, logic [7:0] b, string tag);
        int c;
        c = eff(sel);
        bus = mk(sel, 1, 0, ale, cle, b);
        @(negedge clk);
        if (c >= 0) m_write(c, ale, cle, b);
        bus = mk(sel, 1, 1, 0, 0, b);
        @(negedge clk);
        if (c >= 0) begin m_rdy[c] = 1; m_drv = 0; end
        chk_status(tag);
    endtask

    task automatic op_read(int sel, int hold, string tag);
        int c;
        c = eff(sel);
        bus = mk(sel, 0, 1, 0, 0, 8'h00);
        repeat (hold) @(negedge clk);
        if (c >= 0) begin
            m_data   = pat(m_ptr[c], c);
            m_ptr[c] = (m_ptr[c] + 1) & MASK;
            m_drv    = 1;
        end
        chk({tag, " R6 read data"}, int'(rd_data), m_data);
        chk({tag, " R6 drive"}, int'(rd_drive), int'(m_drv));
        bus = mk(sel, 1, 1, 0, 0, 8'h00);
        @(negedge clk);
        if (c >= 0) begin m_rdy[c] = 1; m_drv = 0; end
        chk_status(tag);
    endtask

    task automatic set_addr(int sel, logic [7:0] cmd, logic [7:0] a0, logic [7:0] a1, logic [7:0] a2, string tag);
        op_write(sel, 0, 1, cmd, tag);
        op_write(sel, 1, 0, a0, tag);
        op_write(sel, 1, 0, a1, tag);
        op_write(sel, 1, 0, a2, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] cmds [3] = '{8'h00, 8'h01, 8'h50};
        logic [7:0] cols [3] = '{8'd0, 8'd7, 8'd255};
        logic [7:0] his  [3] = '{8'd0, 8'd1, 8'd3};
        logic [7:0] los  [3] = '{8'd0, 8'd5, 8'd200};

        do_reset("R1 reset state");

        // R7: ready bits appear per chip on an idle selected cycle
        op_write(0, 0, 0, 8'h00, "R7 idle chip0");
        op_write(1, 0, 0, 8'h00, "R7 idle chip1");

        // R3 R4 R5: sweep modes, columns and page bytes on chip 0
        for (int m = 0; m < 3; m++)
            for (int ci = 0; ci < 3; ci++)
                for (int hi = 0; hi < 3; hi++)
                    for (int li = 0; li < 3; li++) begin
                        set_addr(0, cmds[m], cols[ci], his[hi], los[li], "R3 R4 R5 sweep");
                        op_read(0, 1, "R4 R5 sweep");
                        op_read(0, 1, "R4 R5 sweep");
                    end

        // R11: pointer 65534 crosses the 16-bit wrap
        set_addr(0, 8'h00, 8'd62, 8'd0, 8'd124, "R11 wrap setup");
        for (int k = 0; k < 4; k++) op_read(0, 1, "R11 wrap");

        // R8: a read strobe held low for six cycles advances once
        op_read(0, 6, "R8 held strobe");
        op_read(0, 1, "R8 after hold");

        // R3: command latch wins over address latch
        op_write(0, 1, 1, 8'h01, "R3 latch priority");
        op_write(0, 1, 0, 8'd3, "R3 latch priority");
        op_write(0, 1, 0, 8'd0, "R3 latch priority");
        op_write(0, 1, 0, 8'd1, "R3 latch priority");
        op_read(0, 1, "R3 latch priority");

        // R2: both enables low selects chip 0
        set_addr(2, 8'h50, 8'd9, 8'd0, 8'd2, "R2 both enables");
        op_read(2, 1, "R2 both enables");
        // R10: chip 1 keeps its own pointer
        set_addr(1, 8'h00, 8'd40, 8'd2, 8'd0, "R10 chip1 setup");
        op_read(1, 1, "R10 chip1");
        op_read(0, 1, "R10 chip0 continues");
        op_read(1, 1, "R10 chip1 continues");
        // R2: no enable low, nothing changes
        op_write(3, 0, 1, 8'h00, "R2 no enable cmd");
        op_write(3, 1, 0, 8'h77, "R2 no enable addr");
        op_read(3, 1, "R2 no enable read");
        op_read(0, 1, "R2 chip0 unchanged");
        op_read(1, 1, "R2 chip1 unchanged");

        // R9: fourth address byte
        do_reset("R1 second reset");
        set_addr(0, 8'h01, 8'd5, 8'd0, 8'd1, "R9 fourth addr setup");
        op_write(0, 1, 0, 8'h33, "R9 fourth addr");
        op_read(0, 1, "R9 pointer kept after fourth addr");

        // R9: unknown command keeps mode and pointer
        do_reset("R1 third reset");
        set_addr(1, 8'h50, 8'd17, 8'd0, 8'd3, "R9 unknown cmd setup");
        op_write(1, 0, 1, 8'h90, "R9 unknown cmd");
        op_read(1, 1, "R9 pointer kept after unknown cmd");
        op_read(0, 1, "R10 chip0 untouched by chip1 error");

        // R9: address byte while waiting
        do_reset("R1 fourth reset");
        op_write(0, 1, 0, 8'h12, "R9 addr in wait");
        op_read(0, 1, "R9 pointer kept after addr in wait");
        op_write(0, 0, 1, 8'hFF, "R3 wait command");
        op_write(0, 1, 0, 8'h44, "R3 R9 addr after wait cmd");
        op_read(0, 1, "R9 pointer kept");

        summary();
    end

endmodule